// File: doc/BRIEF.md
# Bus-Interfaced Successive-Approximation Converter Controller

This block is the digital half of a successive-approximation analog-to-digital converter that sits on a microprocessor bus. A bus master starts a conversion or reads the last result through a select pair: an active-high enable and an active-low select. A read/convert strobe picks the operation, and one address bit plays two roles. When a conversion is started, that bit sets its length. When a result is read, it picks one of the two bytes.

While a conversion runs, the block drives a trial code toward an external DAC. It samples a single comparator bit each clock, one bit at a time from the most significant end, and raises a busy status. Once the last bit has been decided, it stores the finished code.

On a read, the stored code is presented either as one 12-bit word or as two byte-wide words that can share an 8-bit bus. Each of the four nybble lanes has its own output enable, so external three-state drivers can be controlled lane by lane.

Top module: `sar_bus_ctrl`

## Requirements
- R1: A convert command is the cycle in which the combined selection (`ce` high and `cs_n` low) goes from inactive to active while `rd_cnv` is low and `sts` is low. In that case `sts` is high in the following cycle.
- R2: While `ce` is low or `cs_n` is high, all four lane enables are low and `data_out` is zero, whatever `rd_cnv`, `addr` and `fmt_wide` hold.
- R3: `addr` is captured at the convert command. A captured 0 keeps `sts` high for exactly 12 cycles, and a captured 1 keeps it high for exactly 8 cycles.
- R4: A command fires only on the transition into selection, so the input that arrives last (enable rising or select falling) starts it. Holding the selection active starts nothing further.
- R5: A read is selection with `rd_cnv` high. With `fmt_wide` high, a read raises `en_a`, `en_b` and `en_c`, leaves `en_z` low, and puts the full 12-bit result on `data_out`.
- R6: With `fmt_wide` low and `addr` 0, a read raises `en_a` and `en_b` only. `data_out[11:4]` carries result bits 11:4 and `data_out[3:0]` is zero.
- R7: With `fmt_wide` low and `addr` 1, a read raises `en_c` and `en_z` only. `data_out[11:8]` carries result bits 3:0 and `data_out[7:0]` is zero, so the byte is the four low bits followed by four zeros.
- R8: In the first busy cycle, `trial` holds only its most significant bit. Each busy clock keeps the trial bit when `cmp_in` is high, clears it otherwise, and moves to the next lower bit. With a comparator that reports input ≥ trial, a 12-bit conversion returns the input code.
- R9: An 8-bit conversion leaves result bits 3:0 at zero. The readable result changes only in the clock where `sts` falls.
- R10: A convert command while `sts` is high is ignored and does not change the length of the running conversion. A read during a conversion returns the previously completed result.
- R11: While `rst_n` is low at a clock edge, `sts`, the stored result, the captured length and the selection history are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Bus enable, active high |
| cs_n | input | 1 | Bus select, active low |
| rd_cnv | input | 1 | 1 selects read, 0 selects convert |
| addr | input | 1 | Length select at convert, byte select at read |
| fmt_wide | input | 1 | 1 selects 12-bit output, 0 selects byte output |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| trial | output | 12 | Trial code driven toward the DAC |
| sts | output | 1 | High while a conversion is running |
| data_out | output | 12 | Formatted result, zero on disabled lanes |
| en_a | output | 1 | Enable for lane 11:8 |
| en_b | output | 1 | Enable for lane 7:4 |
| en_c | output | 1 | Enable for the low-bit nybble lane |
| en_z | output | 1 | Enable for the forced-zero nybble lane |

## Verification
A corrupted bit index or a wrong captured length shows up first on `sts`, which falls one or more cycles early or late relative to the command. The wrong code then appears on `data_out` at the very next read. A stale selection history shows as a spurious `sts` rise in the cycle after a held selection, or as a missing rise after a true re-selection. Lane-steering faults show up combinationally on the enables and data in the same cycle that `addr` or `fmt_wide` changes. The reference model is therefore compared in every cycle.

// File: rtl/sar_pkg.sv
// Package: shared widths and the lane-enable bundle for the converter controller.
// Assumes a 4-bit nybble granularity for all lane steering.
package sar_pkg;
    localparam int NYB_W = 4;

    typedef struct packed {
        logic a;   // lane 11:8
        logic b;   // lane 7:4
        logic c;   // low-bit nybble lane
        logic z;   // forced-zero lane
    } lane_en_t;
endpackage

// File: rtl/sar_cmd_decode.sv
// Module: sar_cmd_decode
// Turns the bus select pair into a one-cycle convert pulse (on entry into selection)
// and a level read strobe. Assumes inputs are synchronous to clk.
module sar_cmd_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce,
    input  logic cs_n,
    input  logic rd_cnv,
    input  logic busy,
    output logic start_cnv,
    output logic rd_active
);
    logic sel;
    logic sel_q;

    assign sel = ce & ~cs_n;

    // Remember last-cycle selection so only the entry edge counts.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= 1'b0;
        else        sel_q <= sel;
    end

    assign start_cnv = sel & ~sel_q & ~rd_cnv & ~busy;
    assign rd_active = sel & rd_cnv;
endmodule

// File: rtl/sar_engine.sv
// Module: sar_engine
// Bit-serial successive approximation, MSB first, one decision per clock.
// Captures the short-length flag at start; result is written only on completion.
// Assumes SHORT_W <= RES_W.
module sar_engine #(
    parameter int RES_W   = 12,
    parameter int SHORT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             short_req,
    input  logic             cmp_in,
    output logic             busy,
    output logic [RES_W-1:0] trial,
    output logic [RES_W-1:0] result
);
    localparam int IDX_W = $clog2(RES_W);
    localparam logic [IDX_W-1:0] IDX_MSB   = IDX_W'(RES_W - 1);
    localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(RES_W - SHORT_W);

    logic [RES_W-1:0] work;
    logic [RES_W-1:0] decided;
    logic [RES_W-1:0] work_nx;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_dn;
    logic [IDX_W-1:0] stop_idx;
    logic             short_q;
    logic             last_bit;

    assign stop_idx = short_q ? IDX_SHORT : '0;
    assign last_bit = (idx == stop_idx);
    assign idx_dn   = idx - 1'b1;

    // Resolve the current trial bit from the comparator and arm the next one.
    always_comb begin
        decided      = work;
        decided[idx] = cmp_in;
        work_nx      = decided;
        if (!last_bit) work_nx[idx_dn] = 1'b1;
    end

    // Sequence the conversion and commit the finished code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            work    <= '0;
            idx     <= '0;
            short_q <= 1'b0;
            result  <= '0;
        end else if (busy) begin
            work <= work_nx;
            if (last_bit) begin
                busy   <= 1'b0;
                result <= decided;
            end else begin
                idx <= idx_dn;
            end
        end else if (start) begin
            busy    <= 1'b1;
            short_q <= short_req;
            idx     <= IDX_MSB;
            work    <= {1'b1, {(RES_W-1){1'b0}}};
        end
    end

    assign trial = work;
endmodule

// File: rtl/sar_out_mux.sv
// Module: sar_out_mux
// Steers the stored code onto the bus lanes for wide or byte reads and raises
// per-lane enables. Disabled lanes read as zero. Assumes RES_W = 3 nybbles.
module sar_out_mux
    import sar_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic             rd_active,
    input  logic             fmt_wide,
    input  logic             addr,
    input  logic [RES_W-1:0] result,
    output logic [RES_W-1:0] data_out,
    output lane_en_t         en
);
    localparam int N_LANE = RES_W / NYB_W;

    logic [RES_W-1:0] src;

    // Pick lane enables and the source word for the current read form.
    always_comb begin
        en  = '0;
        src = '0;
        if (rd_active) begin
            if (fmt_wide) begin
                en.a = 1'b1; en.b = 1'b1; en.c = 1'b1;
                src  = result;
            end else if (!addr) begin
                en.a = 1'b1; en.b = 1'b1;
                src  = {result[RES_W-1:NYB_W], {NYB_W{1'b0}}};
            end else begin
                en.c = 1'b1; en.z = 1'b1;
                src  = {result[NYB_W-1:0], {(RES_W-NYB_W){1'b0}}};
            end
        end
    end

    // Gate each lane by whether any enable drives it.
    for (genvar k = 0; k < N_LANE; k++) begin : g_lane
        logic lane_on;
        if (k == N_LANE - 1) begin : g_top
            assign lane_on = en.a | en.c;
        end else if (k == N_LANE - 2) begin : g_mid
            assign lane_on = en.b | en.z;
        end else begin : g_low
            assign lane_on = en.c & fmt_wide;
        end
        assign data_out[k*NYB_W +: NYB_W] = lane_on ? src[k*NYB_W +: NYB_W] : '0;
    end
endmodule

// File: rtl/sar_bus_ctrl.sv
// Module: sar_bus_ctrl (top)
// Bus-facing controller for a successive-approximation converter: command decode,
// bit-serial approximation engine, and lane-steered result output.
// Assumes all inputs synchronous to clk; reset is synchronous, active low.
module sar_bus_ctrl
    import sar_pkg::*;
#(
    parameter int RES_W   = 12,
    parameter int SHORT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce,
    input  logic             cs_n,
    input  logic             rd_cnv,
    input  logic             addr,
    input  logic             fmt_wide,
    input  logic             cmp_in,
    output logic [RES_W-1:0] trial,
    output logic             sts,
    output logic [RES_W-1:0] data_out,
    output logic             en_a,
    output logic             en_b,
    output logic             en_c,
    output logic             en_z
);
    logic             start_cnv;
    logic             rd_active;
    logic [RES_W-1:0] result_q;
    lane_en_t         lane_en;

    sar_cmd_decode u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce       (ce),
        .cs_n     (cs_n),
        .rd_cnv   (rd_cnv),
        .busy     (sts),
        .start_cnv(start_cnv),
        .rd_active(rd_active)
    );

    sar_engine #(.RES_W(RES_W), .SHORT_W(SHORT_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_cnv),
        .short_req(addr),
        .cmp_in   (cmp_in),
        .busy     (sts),
        .trial    (trial),
        .result   (result_q)
    );

    sar_out_mux #(.RES_W(RES_W)) u_mux (
        .rd_active(rd_active),
        .fmt_wide (fmt_wide),
        .addr     (addr),
        .result   (result_q),
        .data_out (data_out),
        .en       (lane_en)
    );

    assign en_a = lane_en.a;
    assign en_b = lane_en.b;
    assign en_c = lane_en.c;
    assign en_z = lane_en.z;
endmodule

// File: rtl/sar_bus_ctrl_chk.sv
// Module: sar_bus_ctrl_chk
// Temporal checks on the controller's ports and stored result; bound to the top.
module sar_bus_ctrl_chk #(
    parameter int RES_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ce,
    input logic             cs_n,
    input logic             rd_cnv,
    input logic             addr,
    input logic             fmt_wide,
    input logic [RES_W-1:0] trial,
    input logic             sts,
    input logic [RES_W-1:0] data_out,
    input logic             en_a,
    input logic             en_b,
    input logic             en_c,
    input logic             en_z,
    input logic [RES_W-1:0] result_q
);
    logic sel;
    assign sel = ce & ~cs_n;

    assert_cmd_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sel) && !rd_cnv && !sts) |=> sts);

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |-> (!en_a && !en_b && !en_c && !en_z && data_out == '0));

    assert_wide_lanes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_cnv && fmt_wide) |-> (en_a && en_b && en_c && !en_z && data_out == result_q));

    assert_byte_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && rd_cnv && !fmt_wide && addr) |-> (en_z && !en_a && data_out[7:0] == '0));

    assert_first_trial_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts) |-> (trial == {1'b1, {(RES_W-1){1'b0}}}));

    assert_result_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result_q) |-> $fell(sts));

    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sts && result_q == '0));
endmodule

bind sar_bus_ctrl sar_bus_ctrl_chk #(.RES_W(RES_W)) u_chk (.*);

// File: tb/sar_bus_ctrl_bench.sv
// Bench: behavioural per-cycle reference model compared every clock.
module sar_bus_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, ce, cs_n, rd_cnv, addr, fmt_wide, cmp_in;
    logic [11:0] trial, data_out;
    logic        sts, en_a, en_b, en_c, en_z;
    logic [11:0] vin;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;
    string cur_req = "R11";

    // reference state
    int m_sts, m_cnt, m_short, m_selq, m_res;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_in = (vin >= trial);

    sar_bus_ctrl u_sar_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .ce(ce), .cs_n(cs_n), .rd_cnv(rd_cnv),
        .addr(addr), .fmt_wide(fmt_wide), .cmp_in(cmp_in), .trial(trial),
        .sts(sts), .data_out(data_out), .en_a(en_a), .en_b(en_b),
        .en_c(en_c), .en_z(en_z)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit sel, start;
        sel = ce && !cs_n;
        if (!rst_n) begin
            m_sts = 0; m_cnt = 0; m_short = 0; m_selq = 0; m_res = 0;
            return;
        end
        start = sel && !m_selq && !rd_cnv && (m_sts == 0);
        if (m_sts != 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_sts = 0;
                m_res = (m_short != 0) ? (int'(vin) & 'hFF0) : int'(vin);
            end
        end
        if (start) begin
            m_sts = 1; m_short = addr; m_cnt = addr ? 8 : 12;
        end
        m_selq = sel;
    endtask

    task automatic compare();
        int e_en, e_data;
        e_en = 0; e_data = 0;
        if (ce && !cs_n && rd_cnv) begin
            if (fmt_wide) begin e_en = 'b1110; e_data = m_res; end
            else if (!addr) begin e_en = 'b1100; e_data = m_res & 'hFF0; end
            else begin e_en = 'b0011; e_data = (m_res & 'hF) << 8; end
        end
        check({cur_req, " sts"}, sts, m_sts);
        check({cur_req, " lanes"}, {en_a, en_b, en_c, en_z}, e_en);
        check({cur_req, " data"}, data_out, e_data);
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic deselect();
        ce = 1'b0; cs_n = 1'b1; rd_cnv = 1'b1;
    endtask

    initial begin
        rst_n = 0; ce = 0; cs_n = 1; rd_cnv = 1; addr = 0; fmt_wide = 1; vin = '0;
        // R11: reset state
        cur_req = "R11";
        ticks(3);
        rst_n = 1;
        tick();

        // R1 R3 R8: full conversion, enable rises last
        cur_req = "R1"; vin = 12'hA5C;
        cs_n = 0; rd_cnv = 0; addr = 0; tick();
        ce = 1; tick();
        check("R8 first trial", trial, 12'h800);
        cur_req = "R3"; deselect(); ticks(13);

        // R5 R6 R7: read forms
        cur_req = "R5"; ce = 1; cs_n = 0; rd_cnv = 1; fmt_wide = 1; tick();
        cur_req = "R6"; fmt_wide = 0; addr = 0; tick();
        cur_req = "R7"; addr = 1; tick();
        cur_req = "R2"; ce = 0; tick(); fmt_wide = 1; tick(); deselect(); tick();

        // R4 R9: short conversion, select falls last
        cur_req = "R4"; vin = 12'h3C7; ce = 1; rd_cnv = 0; addr = 1; tick();
        cs_n = 0; tick();
        cur_req = "R10"; ce = 0; addr = 0; tick();
        // read during conversion returns old code
        ce = 1; rd_cnv = 1; fmt_wide = 1; tick();
        // convert command while busy is ignored
        deselect(); tick(); ce = 1; cs_n = 0; rd_cnv = 0; addr = 0; tick();
        cur_req = "R9"; deselect(); ticks(6);
        ce = 1; cs_n = 0; rd_cnv = 1; fmt_wide = 0; addr = 1; tick();
        fmt_wide = 1; tick();

        // R4: held selection starts nothing new
        cur_req = "R4"; deselect(); tick();
        vin = 12'hFFF; ce = 1; cs_n = 0; rd_cnv = 0; addr = 0; ticks(16);
        rd_cnv = 1; tick(); rd_cnv = 0; ticks(3);
        deselect(); tick();

        // R8: lower boundary code
        cur_req = "R8"; vin = 12'h000; ce = 1; cs_n = 0; rd_cnv = 0; tick();
        deselect(); ticks(13);
        ce = 1; cs_n = 0; rd_cnv = 1; fmt_wide = 1; tick();
        vin = 12'h001; deselect(); tick();
        ce = 1; cs_n = 0; rd_cnv = 0; tick(); deselect(); ticks(13);
        ce = 1; cs_n = 0; rd_cnv = 1; tick(); deselect(); tick();

        // R11: reset mid-conversion
        cur_req = "R11"; vin = 12'h5A5; ce = 1; cs_n = 0; rd_cnv = 0; addr = 1; tick();
        deselect(); ticks(3);
        rst_n = 0; ticks(2); rst_n = 1; tick();
        ce = 1; cs_n = 0; rd_cnv = 1; fmt_wide = 1; tick();
        deselect(); tick();

        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule